// File: doc/BRIEF.md
# Classification Output Array Scorer

This block grades how well a trained analog network separates its input classes. It takes a square array of measured output magnitudes. Each row belongs to one applied input pattern and each column to one sensed output. From the array it produces two figures of merit. The first is a signed fitness value, which rewards every row where exactly one output stands out. The second is a success count, which counts the entries that are strictly the largest in both their row and their column. When every row and every column has such an entry, the array behaves like a permutation matrix.

The array arrives as a stream of unsigned integers in row-major order, one entry per accepted cycle. An entry counts as "high" when it reaches a programmable fraction of its row's largest value. That fraction is an unsigned fixed-point number. A smaller fraction lets more entries reach the threshold, so the test becomes stricter. The block stores the whole array, then makes one pass over the rows and one pass over the columns. It then presents both results together with a one-cycle done strobe.

Top module: `cls_array_scorer`

## Requirements
- R1: After reset, `done` is 0, `fitness` is 0 and `successCount` is 0.
- R2: While the block is idle, each cycle with `inValid` high stores `inData` as the next entry of an N x N array (row index major, column index minor). `tolFrac` is captured in the same cycle as entry N*N-1, which starts scoring.
- R3: Entry e in a row whose maximum is m > 0 is high exactly when e * 2^F >= tolFrac * m. Here `tolFrac` is unsigned with F fractional bits, so 2^F means 1.0.
- R4: A row with exactly one high entry adds +3 to the fitness.
- R5: A row with k > 1 high entries subtracts k from the fitness.
- R6: A row whose maximum is zero changes neither the fitness nor the success count.
- R7: `successCount` is the number of nonzero entries that are strictly greater than every other entry of their row and strictly greater than every other entry of their column. A tie in either direction gives no success.
- R8: `done` is high for exactly one cycle. That cycle follows the (2N+1)-th rising edge after the edge that accepted entry N*N-1. The results appear together with `done` and hold until the next `done`.
- R9: While scoring is in progress, `inValid`, `inData` and `tolFrac` are ignored. They do not change the current results, and they do not store entries into the next array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Entry strobe for the array stream |
| inData | input | W | Unsigned array entry |
| tolFrac | input | F+1 | Tolerance fraction, F fractional bits |
| done | output | 1 | One-cycle result strobe |
| fitness | output | clog2(N*N+1)+3 | Signed fitness score |
| successCount | output | clog2(N+1) | Number of row-and-column unique maxima |

## Verification
Several internal faults surface at a predictable point:
- A corrupted row maximum or stored tolerance shows up as a wrong fitness at the very next `done`, because every high decision in that row depends on them.
- A row's recorded winner index that is off by one cannot be seen in the fitness. It shows up only in `successCount`, and only when that column's unique maximum falls in the affected row.
- A load pointer that does not stop while scoring shifts every later entry. The damage appears one full array later, and that is why junk input is driven during scoring and the next result is then compared.
- A sequencer that is off by a cycle moves `done` away from its predicted cycle. The cycle-accurate reference model catches this on the first result.

// File: rtl/cls_score_pkg.sv
package cls_score_pkg;

  typedef struct packed {
    logic loadEn;
    logic lastLoad;
    logic rowEn;
    logic colEn;
    logic finish;
  } ctrl_t;

endpackage

// File: rtl/cls_score_ctrl.sv
module cls_score_ctrl
  import cls_score_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output ctrl_t                       strobe,
  output logic [$clog2(N*N)-1:0]      loadIdx,
  output logic [$clog2(N)-1:0]        passIdx
);

  localparam int IW = $clog2(N*N);
  localparam int PIW = $clog2(N);
  localparam logic [IW-1:0] LAST_ENTRY = IW'(N*N-1);
  localparam logic [PIW-1:0] LAST_PASS = PIW'(N-1);

  typedef enum logic [1:0] {S_LOAD, S_ROW, S_COL, S_FIN} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_LOAD;
      loadIdx <= '0;
      passIdx <= '0;
    end else begin
      case (state)
        S_LOAD: if (inValid) begin
          if (loadIdx == LAST_ENTRY) begin
            loadIdx <= '0;
            passIdx <= '0;
            state   <= S_ROW;
          end else begin
            loadIdx <= loadIdx + 1'b1;
          end
        end
        S_ROW: begin
          if (passIdx == LAST_PASS) begin
            passIdx <= '0;
            state   <= S_COL;
          end else begin
            passIdx <= passIdx + 1'b1;
          end
        end
        S_COL: begin
          if (passIdx == LAST_PASS) begin
            passIdx <= '0;
            state   <= S_FIN;
          end else begin
            passIdx <= passIdx + 1'b1;
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  always_comb begin
    strobe.loadEn   = (state == S_LOAD) && inValid;
    strobe.lastLoad = strobe.loadEn && (loadIdx == LAST_ENTRY);
    strobe.rowEn    = (state == S_ROW);
    strobe.colEn    = (state == S_COL);
    strobe.finish   = (state == S_FIN);
  end

endmodule

// File: rtl/cls_vec_max.sv
module cls_vec_max #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N*W-1:0]        vec,
  output logic [W-1:0]          maxVal,
  output logic                  isSingle,
  output logic [$clog2(N)-1:0]  argIdx
);

  localparam int PIW = $clog2(N);
  localparam int CW = $clog2(N+1);

  logic [CW-1:0] tieCnt;

  always_comb begin
    maxVal = '0;
    argIdx = '0;
    for (int j = 0; j < N; j++) begin
      if (vec[j*W +: W] > maxVal) begin
        maxVal = vec[j*W +: W];
        argIdx = PIW'(j);
      end
    end
    tieCnt = '0;
    for (int j = 0; j < N; j++) begin
      if (vec[j*W +: W] == maxVal) tieCnt = tieCnt + 1'b1;
    end
    isSingle = (tieCnt == CW'(1));
  end

endmodule

// File: rtl/cls_score_datapath.sv
module cls_score_datapath
  import cls_score_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrl_t                              strobe,
  input  logic [$clog2(N*N)-1:0]             loadIdx,
  input  logic [$clog2(N)-1:0]               passIdx,
  input  logic [W-1:0]                       inData,
  input  logic [F:0]                         tolFrac,
  output logic                               done,
  output logic signed [$clog2(N*N+1)+2:0]    fitness,
  output logic [$clog2(N+1)-1:0]             successCount
);

  localparam int IW  = $clog2(N*N);
  localparam int PIW = $clog2(N);
  localparam int TW  = F + 1;
  localparam int PW  = W + TW;
  localparam int FW  = $clog2(N*N+1) + 3;
  localparam int SW  = $clog2(N+1);
  localparam int CW  = $clog2(N+1);

  logic [W-1:0]   cells [N*N];
  logic [TW-1:0]  tolReg;
  logic [N*W-1:0] rowVec, colVec;
  logic [W-1:0]   rowMax, colMax;
  logic           rowIsSingle, colIsSingle;
  logic [PIW-1:0] rowArgIdx, colArgIdx;
  logic [N-1:0]   hiBit;
  logic [CW-1:0]  hiCnt;
  logic [N-1:0]   rowSingle;
  logic [PIW-1:0] rowArg [N];
  logic           colHit;
  logic signed [FW-1:0] fitAcc;
  logic [SW-1:0]  succAcc;

  always_ff @(posedge clk) begin
    if (strobe.loadEn) cells[loadIdx] <= inData;
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      rowVec[j*W +: W] = cells[IW'(int'(passIdx) * N + j)];
      colVec[j*W +: W] = cells[IW'(j * N + int'(passIdx))];
    end
  end

  cls_vec_max #(.N(N), .W(W)) i_rowMax (
    .vec(rowVec), .maxVal(rowMax), .isSingle(rowIsSingle), .argIdx(rowArgIdx)
  );

  cls_vec_max #(.N(N), .W(W)) i_colMax (
    .vec(colVec), .maxVal(colMax), .isSingle(colIsSingle), .argIdx(colArgIdx)
  );

  logic [PW-1:0] threshold;
  assign threshold = PW'(tolReg) * PW'(rowMax);

  for (genvar j = 0; j < N; j++) begin : g_high
    logic [PW-1:0] scaled;
    assign scaled   = PW'({rowVec[j*W +: W], {F{1'b0}}});
    assign hiBit[j] = (rowMax != '0) && (scaled >= threshold);
  end

  assign hiCnt = CW'($countones(hiBit));

  assign colHit = colIsSingle && (colMax != '0) &&
                  rowSingle[colArgIdx] && (rowArg[colArgIdx] == passIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tolReg       <= '0;
      fitAcc       <= '0;
      succAcc      <= '0;
      rowSingle    <= '0;
      done         <= 1'b0;
      fitness      <= '0;
      successCount <= '0;
      for (int r = 0; r < N; r++) rowArg[r] <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.lastLoad) begin
        tolReg  <= tolFrac;
        fitAcc  <= '0;
        succAcc <= '0;
      end
      if (strobe.rowEn) begin
        rowSingle[passIdx] <= rowIsSingle && (rowMax != '0);
        rowArg[passIdx]    <= rowArgIdx;
        if (hiCnt == CW'(1)) begin
          fitAcc <= fitAcc + FW'(3);
        end else if (hiCnt > CW'(1)) begin
          fitAcc <= fitAcc - FW'(hiCnt);
        end
      end
      if (strobe.colEn && colHit) begin
        succAcc <= succAcc + 1'b1;
      end
      if (strobe.finish) begin
        fitness      <= fitAcc;
        successCount <= succAcc;
        done         <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cls_array_scorer.sv
module cls_array_scorer
  import cls_score_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             inValid,
  input  logic [W-1:0]                     inData,
  input  logic [F:0]                       tolFrac,
  output logic                             done,
  output logic signed [$clog2(N*N+1)+2:0]  fitness,
  output logic [$clog2(N+1)-1:0]           successCount
);

  ctrl_t                   strobe;
  logic [$clog2(N*N)-1:0]  loadIdx;
  logic [$clog2(N)-1:0]    passIdx;

  cls_score_ctrl #(.N(N)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .loadIdx(loadIdx), .passIdx(passIdx)
  );

  cls_score_datapath #(.N(N), .W(W), .F(F)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .passIdx(passIdx), .inData(inData), .tolFrac(tolFrac),
    .done(done), .fitness(fitness), .successCount(successCount)
  );

endmodule

// File: rtl/cls_array_scorer_checker.sv
module cls_array_scorer_checker #(
  parameter int N = 8
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             done,
  input logic signed [$clog2(N*N+1)+2:0]  fitness,
  input logic [$clog2(N+1)-1:0]           successCount
);

  localparam int GW = $clog2(N*N + 2*N + 4) + 1;
  logic [GW-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= GW'(N*N);
    else if (done) gapCnt <= '0;
    else if (gapCnt != {GW{1'b1}}) gapCnt <= gapCnt + 1'b1;
  end

  // R8: the strobe lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: results hold between strobes
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(fitness) && $stable(successCount)));

  // R8: two strobes are at least one full array load apart
  assert_done_spacing_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(gapCnt) >= N*N));

  // R7: at most one success per column
  assert_success_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(successCount) <= N));

  // R4, R5: fitness stays between all-rows-crowded and all-rows-single
  assert_fit_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((int'(fitness) >= -(N*N)) && (int'(fitness) <= 3*N)));

endmodule

bind cls_array_scorer cls_array_scorer_checker #(.N(N)) i_checker (
  .clk(clk), .rstN(rstN), .done(done),
  .fitness(fitness), .successCount(successCount)
);

// File: tb/test_cls_array_scorer.sv
module test_cls_array_scorer;

  localparam int N = 8;
  localparam int W = 16;
  localparam int F = 8;
  localparam int NN = N * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic [F:0] tolFrac = '0;
  logic done;
  logic signed [$clog2(N*N+1)+2:0] fitness;
  logic [$clog2(N+1)-1:0] successCount;

  always #4 clk = ~clk;

  cls_array_scorer #(.N(N), .W(W), .F(F)) i_cls_array_scorer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .tolFrac(tolFrac), .done(done), .fitness(fitness),
    .successCount(successCount)
  );

  int vecs = 0;
  int fails = 0;
  int cyc = 0;
  string curReq = "R1";
  int mat [NN];
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int mCells [NN];
  int mCnt = 0;
  bit mBusy = 0;
  int mSince = 0;
  int pendFit = 0, pendSucc = 0;
  bit expDone = 0;
  int expFit = 0, expSucc = 0;

  task automatic refScore(input int tolv, output int fit, output int succ);
    fit = 0;
    succ = 0;
    for (int r = 0; r < N; r++) begin
      int mx = 0;
      int hi = 0;
      for (int c = 0; c < N; c++) if (mCells[r*N+c] > mx) mx = mCells[r*N+c];
      if (mx == 0) continue;
      for (int c = 0; c < N; c++)
        if (longint'(mCells[r*N+c]) * (longint'(1) << F) >= longint'(tolv) * mx) hi++;
      if (hi == 1) fit += 3;
      else if (hi > 1) fit -= hi;
    end
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        int v = mCells[r*N+c];
        bit ok = (v != 0);
        for (int k = 0; k < N; k++) begin
          if (k != c && mCells[r*N+k] >= v) ok = 0;
          if (k != r && mCells[k*N+c] >= v) ok = 0;
        end
        if (ok) succ++;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    expDone = 0;
    if (!rstN) begin
      mCnt = 0; mBusy = 0; mSince = 0;
      expFit = 0; expSucc = 0;
    end else if (mBusy) begin
      mSince++;
      if (mSince == 2*N + 1) begin
        expDone = 1;
        expFit = pendFit;
        expSucc = pendSucc;
        mBusy = 0;
      end
    end else if (inValid) begin
      mCells[mCnt] = int'(inData);
      mCnt++;
      if (mCnt == NN) begin
        mCnt = 0;
        mBusy = 1;
        mSince = 0;
        refScore(int'(tolFrac), pendFit, pendSucc);
      end
    end
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 50000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      vecs++;
      if (done !== expDone) begin
        fails++;
        $display("FAIL R8: done actual %0b expected %0b", done, expDone);
      end
      if (int'(fitness) != expFit) begin
        fails++;
        $display("FAIL %s: fitness actual %0d expected %0d", curReq, int'(fitness), expFit);
      end
      if (int'(successCount) != expSucc) begin
        fails++;
        $display("FAIL %s: successCount actual %0d expected %0d", curReq, int'(successCount), expSucc);
      end
    end
  end

  function automatic logic [15:0] stepLfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic sendMat(input int tolv, input bit junk);
    for (int k = 0; k < NN; k++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = W'(mat[k]);
      tolFrac = (F+1)'(tolv);
    end
    if (junk) begin
      for (int i = 0; i < 2*N + 1; i++) begin
        @(negedge clk);
        lfsr = stepLfsr(lfsr);
        inValid = 1'b1;
        inData = lfsr;
        tolFrac = lfsr[F:0];
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (2*N + 4) @(negedge clk);
  endtask

  task automatic fillRandom(input int mask);
    for (int k = 0; k < NN; k++) begin
      lfsr = stepLfsr(lfsr);
      mat[k] = int'(lfsr) & mask;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    vecs++;
    if (done !== 1'b0 || int'(fitness) != 0 || int'(successCount) != 0) begin
      fails++;
      $display("FAIL R1: reset outputs actual %0b/%0d/%0d expected 0/0/0",
               done, int'(fitness), int'(successCount));
    end
    rstN = 1'b1;

    // R4: one dominant output per row, diagonal
    curReq = "R4";
    for (int k = 0; k < NN; k++) mat[k] = ((k / N) == (k % N)) ? 1000 : 10;
    sendMat(192, 0);

    // R5: every row flat, all entries high, ties everywhere
    curReq = "R5";
    for (int k = 0; k < NN; k++) mat[k] = 500;
    sendMat(192, 0);

    // R6: zero array
    curReq = "R6";
    for (int k = 0; k < NN; k++) mat[k] = 0;
    sendMat(192, 0);

    // R3: threshold boundary, 192/256 of max, at and just above
    curReq = "R3";
    for (int k = 0; k < NN; k++) begin
      int c = k % N;
      mat[k] = (c == 0) ? 256 : (c == 1) ? 192 : (c == 2) ? 191 : 0;
    end
    sendMat(192, 0);
    sendMat(193, 0);
    sendMat(64, 0);

    // R7: column clash and column tie reduce successes
    curReq = "R7";
    for (int k = 0; k < NN; k++) mat[k] = ((k / N) == (k % N)) ? 1000 : 10;
    mat[1*N+1] = 10; mat[1*N+0] = 900;
    mat[2*N+2] = 10; mat[2*N+3] = 1000;
    sendMat(230, 0);

    // R2: streamed pseudo-random arrays at several tolerances
    curReq = "R2";
    fillRandom(16'hFFFF); sendMat(200, 0);
    fillRandom(16'h000F); sendMat(128, 0);
    fillRandom(16'h00FF); sendMat(256, 0);

    // R9: junk input and tolerance changes while scoring
    curReq = "R9";
    fillRandom(16'h03FF); sendMat(180, 1);
    fillRandom(16'h00FF); sendMat(220, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule